// File: doc/BRIEF.md
# Cascadable Serial LCD Segment Driver

This block drives a static LCD panel with one output per segment. Segment data arrives one bit per rising edge of the serial clock. It moves through a shift register as long as the segment count. The top bit of that register is re-timed onto the falling clock edge and sent out as a cascade output, so several drivers can share one data line in a chain.

A load strobe, synchronous with the serial clock, selects which shifted frame is shown. The driver counts rising edges while the strobe stays high. On the eighth such edge (the count is a parameter), it copies the frame into an output latch. That frame includes the bit shifted in on the same edge. Each latch bit is combined with the backplane square wave by exclusive-OR to form the segment waveform. The backplane is also passed to an output pin, so the next driver in the chain uses the same phase.

Top module: `lcd_seg_driver`

## Requirements
- R1: On every rising clock edge, `ser_din` enters shift position 0 and every other position moves one place up. After SEG_COUNT shifts, the first bit of a frame sits in position SEG_COUNT-1 and drives segment SEG_COUNT-1, and the last bit drives segment 0.
- R2: `cas_dout` takes the value of the top shift position on the falling clock edge. Between a rising edge and the next falling edge it keeps its earlier value.
- R3: When `load` is sampled high on LOAD_DELAY (default 8) consecutive rising edges, the latch takes the shifted frame on the last of those edges. That frame includes the bit entered on that edge.
- R4: If `load` falls before the LOAD_DELAY-th edge, the latch does not change, and the edge count starts again from one at the next high sample.
- R5: Holding `load` high longer than LOAD_DELAY edges updates the latch only once. A new update needs `load` to be sampled low first.
- R6: `seg_out[i]` equals latch bit i XOR `bp_in` for every segment, and `bp_out` equals `bp_in` with no added delay.
- R7: While `rst_n` is sampled low (synchronous, active low), the shift register, the latch and `cas_dout` are cleared, so every segment output equals `bp_in`.
- R8: Shifting without a completed load count leaves the latch, and so the segment pattern, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; shift on rising edge, cascade on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_din | input | 1 | Serial segment data |
| load | input | 1 | Synchronous load strobe |
| bp_in | input | 1 | Backplane waveform input |
| seg_out | output | SEG_COUNT | Segment drive waveforms |
| cas_dout | output | 1 | Cascade data for the next driver |
| bp_out | output | 1 | Forwarded backplane |

## Verification
The assertions assume four things: `ser_din`, `load` and `rst_n` change only away from the rising edge, `bp_in` is steady at each rising edge, LOAD_DELAY is at least two, and reset is held across at least one full clock period. The checker keeps its own count of consecutive high `load` samples and predicts each latch update from it. It reads the latch back from `seg_out` and `bp_in`, so it does not depend on the design's internal timer. The stimulus changes every input seven nanoseconds after a rising edge, after the falling edge and well before the next rising edge. It uses load bursts both shorter and longer than the load count, toggles the backplane, and applies occasional resets in the middle of a frame.

// File: rtl/lcdseg_pkg.sv
// Package lcdseg_pkg
// Shared defaults and the load timer state type for the segment driver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lcdseg_pkg;

    parameter int unsigned SEG_COUNT_DEF  = 46;
    parameter int unsigned LOAD_DELAY_DEF = 8;

    // States of the load edge counter.
    typedef enum logic [1:0] {
        TMR_ARMED = 2'd0,   // waiting for load to be sampled high
        TMR_COUNT = 2'd1,   // counting consecutive high samples
        TMR_SPENT = 2'd2    // update done, waiting for load low
    } load_tmr_e;

endpackage

// File: rtl/seg_shift_chain.sv
// Module seg_shift_chain
// Serial-in shift register of SEG_COUNT bits. Data enters bit 0 on the
// rising edge. The top bit is re-timed to the falling edge for the cascade
// output. The next-state value is also exported, so a latch can capture the
// frame including the bit entered on the current edge.
// Assumes ser_din is steady around the rising edge; rst_n is synchronous.
module seg_shift_chain #(
    parameter int unsigned SEG_COUNT = lcdseg_pkg::SEG_COUNT_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_din,
    output logic [SEG_COUNT-1:0] shreg_o,
    output logic [SEG_COUNT-1:0] shnext_o,
    output logic                 cas_o
);

    localparam int unsigned TOP = SEG_COUNT - 1;

    logic [SEG_COUNT-1:0] shreg_q;
    logic                 cas_q;

    // Next shift value: new bit at position 0, the rest move up by one.
    always_comb begin
        shnext_o = {shreg_q[TOP-1:0], ser_din};
    end

    // Shift register stage, updated on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else begin
            shreg_q <= shnext_o;
        end
    end

    // Cascade stage, re-times the top bit to the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            cas_q <= 1'b0;
        end else begin
            cas_q <= shreg_q[TOP];
        end
    end

    assign shreg_o = shreg_q;
    assign cas_o   = cas_q;

endmodule

// File: rtl/seg_load_timer.sv
// Module seg_load_timer
// Counts consecutive rising edges that sample load high and raises fire_o
// (combinational) during the LOAD_DELAY-th one. After firing it waits in
// SPENT until load is seen low, so a long strobe fires only once.
// Assumes LOAD_DELAY >= 2 and load steady around the rising edge.
module seg_load_timer
    import lcdseg_pkg::*;
#(
    parameter int unsigned LOAD_DELAY = lcdseg_pkg::LOAD_DELAY_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic fire_o
);

    localparam int unsigned CNT_W = (LOAD_DELAY > 2) ? $clog2(LOAD_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_DELAY - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    load_tmr_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Fire on the edge that completes the required run of high samples.
    always_comb begin
        fire_o = load && (state_q == TMR_COUNT) && (cnt_q == CNT_LAST);
    end

    // Next-state logic for the edge counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!load) begin
            state_d = TMR_ARMED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_ARMED: begin
                    state_d = TMR_COUNT;
                    cnt_d   = CNT_ONE;
                end
                TMR_COUNT: begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = TMR_SPENT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                TMR_SPENT: begin
                    state_d = TMR_SPENT;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = TMR_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/seg_frame_latch.sv
// Module seg_frame_latch
// Holds the displayed frame and forms the segment waveforms by XOR with the
// backplane. The backplane passes straight through, so chained drivers keep
// the same phase. Assumes cap_en is a single-cycle strobe from the timer.
module seg_frame_latch #(
    parameter int unsigned SEG_COUNT = lcdseg_pkg::SEG_COUNT_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [SEG_COUNT-1:0] frame_i,
    input  logic                 bp_in,
    output logic [SEG_COUNT-1:0] seg_o,
    output logic                 bp_o
);

    logic [SEG_COUNT-1:0] latch_q;

    // Display latch, loaded only when the timer fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (cap_en) begin
            latch_q <= frame_i;
        end
    end

    // One XOR drive cell per segment.
    for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_drive
        assign seg_o[gi] = latch_q[gi] ^ bp_in;
    end

    assign bp_o = bp_in;

endmodule

// File: rtl/lcd_seg_driver.sv
// Module lcd_seg_driver (top)
// Serial LCD segment driver: shift chain with falling-edge cascade output,
// load edge timer, display latch and XOR backplane drive.
// Assumes SEG_COUNT >= 2, LOAD_DELAY >= 2, synchronous active-low reset.
module lcd_seg_driver #(
    parameter int unsigned SEG_COUNT  = lcdseg_pkg::SEG_COUNT_DEF,
    parameter int unsigned LOAD_DELAY = lcdseg_pkg::LOAD_DELAY_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_din,
    input  logic                 load,
    input  logic                 bp_in,
    output logic [SEG_COUNT-1:0] seg_out,
    output logic                 cas_dout,
    output logic                 bp_out
);

    logic [SEG_COUNT-1:0] shreg_q;
    logic [SEG_COUNT-1:0] shnext;
    logic                 fire;

    // Serial input and cascade path.
    seg_shift_chain #(.SEG_COUNT(SEG_COUNT)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_din  (ser_din),
        .shreg_o  (shreg_q),
        .shnext_o (shnext),
        .cas_o    (cas_dout)
    );

    // Load strobe edge counter.
    seg_load_timer #(.LOAD_DELAY(LOAD_DELAY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .fire_o (fire)
    );

    // Display latch and drive.
    seg_frame_latch #(.SEG_COUNT(SEG_COUNT)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (fire),
        .frame_i (shnext),
        .bp_in   (bp_in),
        .seg_o   (seg_out),
        .bp_o    (bp_out)
    );

endmodule

// File: rtl/lcd_seg_driver_chk.sv
// Module lcd_seg_driver_chk
// Property checker bound to lcd_seg_driver. It keeps its own run counter of
// high load samples and reads the latch back from seg_out XOR bp_in.
module lcd_seg_driver_chk #(
    parameter int unsigned SEG_COUNT  = 46,
    parameter int unsigned LOAD_DELAY = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ser_din,
    input logic                 load,
    input logic                 bp_in,
    input logic [SEG_COUNT-1:0] seg_out,
    input logic                 cas_dout,
    input logic [SEG_COUNT-1:0] shreg
);

    localparam int unsigned RUN_W = $clog2(LOAD_DELAY + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOAD_DELAY - 1);
    localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(LOAD_DELAY);

    logic [RUN_W-1:0]     run_q;
    logic [SEG_COUNT-1:0] latch_view;
    logic                 due;

    assign latch_view = seg_out ^ {SEG_COUNT{bp_in}};
    assign due        = load && (run_q == RUN_LAST);

    // Saturating count of consecutive high load samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !load) begin
            run_q <= '0;
        end else if (run_q != RUN_SAT) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    // R1: register shifts by one with the new bit at position 0.
    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> shreg == {$past(shreg[SEG_COUNT-2:0]), $past(ser_din)});

    // R2: cascade output mirrors the top bit between falling edges.
    a_r2_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        cas_dout == shreg[SEG_COUNT-1]);

    // R3: latch takes the post-shift frame on the completing edge.
    a_r3_load_update: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> latch_view == {$past(shreg[SEG_COUNT-2:0]), $past(ser_din)});

    // R4, R5, R8: without a completing edge the latch holds.
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !due |=> latch_view == $past(latch_view));

    // R7: leaving reset finds everything cleared.
    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (shreg == '0) && (latch_view == '0) && !cas_dout);

endmodule

bind lcd_seg_driver lcd_seg_driver_chk #(
    .SEG_COUNT  (SEG_COUNT),
    .LOAD_DELAY (LOAD_DELAY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_din  (ser_din),
    .load     (load),
    .bp_in    (bp_in),
    .seg_out  (seg_out),
    .cas_dout (cas_dout),
    .shreg    (shreg_q)
);

// File: tb/tb_lcd_seg_driver.sv
module tb_lcd_seg_driver;

    localparam int N  = 46;
    localparam int LD = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_din = 1'b0;
    logic         load = 1'b0;
    logic         bp_in = 1'b0;
    logic [N-1:0] seg_out;
    logic         cas_dout;
    logic         bp_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_sh = '0;
    logic [N-1:0] m_lat = '0;
    int           m_run = 0;

    always #5 clk = ~clk;

    lcd_seg_driver #(.SEG_COUNT(N), .LOAD_DELAY(LD)) dut (
        .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .load(load),
        .bp_in(bp_in), .seg_out(seg_out), .cas_dout(cas_dout), .bp_out(bp_out)
    );

    function automatic logic [N-1:0] drive_of(logic [N-1:0] lat, logic bp);
        return lat ^ {N{bp}};
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs set at +7 after a rising edge, outputs checked 7 ns
    // after the next rising edge (past the falling edge).
    task automatic step(string req, logic r, logic d, logic l, logic b);
        logic [N-1:0] nsh;
        rst_n = r; ser_din = d; load = l; bp_in = b;
        @(posedge clk);
        #7;
        if (!r) begin
            m_sh = '0; m_lat = '0; m_run = 0;
        end else begin
            nsh = {m_sh[N-2:0], d};
            if (l && m_run == LD - 1) m_lat = nsh;
            if (!l) m_run = 0;
            else if (m_run < LD) m_run++;
            m_sh = nsh;
        end
        check(req, seg_out, drive_of(m_lat, b));
        check("R2", N'(cas_dout), N'(m_sh[N-1]));
        check("R6", N'(bp_out), N'(b));
    endtask

    logic [N-1:0] pat;
    logic [N-1:0] held;

    initial begin
        void'($urandom(32'h0000_5A17));
        @(posedge clk); #7;
        // R7: reset state
        step("R7", 1'b0, 1'b1, 1'b0, 1'b1);
        check("R7", seg_out, {N{1'b1}});
        step("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7", N'(cas_dout), '0);

        // R1, R3: directed frame, load raised for the last LD bits
        pat = {N{1'b0}};
        for (int i = 0; i < N; i++) pat[i] = ((i % 3) == 0) ^ (i > 40);
        for (int i = 0; i < N; i++)
            step("R3", 1'b1, pat[N-1-i], (i >= N - LD), 1'b0);
        check("R1", seg_out, pat);
        check("R1", N'(seg_out[N-1]), N'(pat[N-1]));
        check("R3", N'(seg_out[0]), N'(pat[0]));
        held = seg_out;

        // R8: shifting without load keeps the display
        for (int i = 0; i < 20; i++) step("R8", 1'b1, i[0], 1'b0, 1'b0);
        check("R8", seg_out, held);

        // R4: load dropped after LD-3 edges, no update
        for (int i = 0; i < LD - 3; i++) step("R4", 1'b1, 1'b1, 1'b1, 1'b0);
        step("R4", 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4", seg_out, held);
        // R4: count restarts from one: LD-1 highs give no update
        for (int i = 0; i < LD - 1; i++) step("R4", 1'b1, 1'b1, 1'b1, 1'b0);
        check("R4", seg_out, held);
        step("R3", 1'b1, 1'b1, 1'b1, 1'b0);
        check("R3", seg_out, m_sh);

        // R5: load held high well past LD edges, one update only
        held = seg_out;
        for (int i = 0; i < 3 * LD; i++) step("R5", 1'b1, ~i[1], 1'b1, 1'b0);
        check("R5", seg_out, held);

        // R6: backplane toggling flips every segment
        for (int i = 0; i < 6; i++) step("R6", 1'b1, 1'b0, 1'b0, i[0]);

        // R2: cascade holds until the falling edge
        for (int i = 0; i < N; i++) step("R2", 1'b1, i[0], 1'b0, 1'b0);
        begin
            logic old_top;
            old_top = m_sh[N-1];
            ser_din = 1'b0; load = 1'b0;
            @(posedge clk); #2;
            check("R2", N'(cas_dout), N'(old_top));
            #5;
            m_sh = {m_sh[N-2:0], 1'b0};
            m_run = 0;
            check("R2", N'(cas_dout), N'(m_sh[N-1]));
        end

        // Random bursts of load, random data and backplane, rare resets
        begin
            int lrun = 0;
            logic lv = 1'b0;
            for (int i = 0; i < 3000; i++) begin
                logic r;
                if (lrun == 0) begin
                    lv = ~lv;
                    lrun = lv ? int'($urandom_range(14, 3)) : int'($urandom_range(5, 1));
                end
                lrun--;
                r = ($urandom_range(199, 0) != 0);
                step(r ? "R3" : "R7", r, 1'($urandom), lv, 1'($urandom));
            end
        end

        // R7: reset in the middle of a frame clears everything
        for (int i = 0; i < LD; i++) step("R3", 1'b1, 1'b1, 1'b1, 1'b1);
        step("R7", 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7", seg_out, '0);
        check("R7", N'(cas_dout), '0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule